// File: doc/BRIEF.md
# MDIO PHY Startup Configuration Sequencer

This block brings a single-pair automotive Ethernet PHY up as link master without any processor help. After a one-cycle `start` pulse it drives the MDIO management pins through a fixed list of Clause 22 write frames. It issues no reads and does not poll between writes. Registers above address 0x1F are reached through the indirect MMD control/data register pair. It holds the sequence for a settle time after the hard reset and after the first soft reset.

When the last write has been shifted out, the block raises `cfg_done` and starts a link timer. It raises `link_up` if the synchronised `link_in` goes high before the timer expires, and raises `timeout` if it does not. A new `start` pulse aborts whatever is in progress and runs the whole sequence again from the first write.

Top module: `mdio_bringup_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `mdio_oe`, `busy`, `cfg_done`, `link_up` and `timeout` are all 0.
- R2: Each write frame is 64 bits, sent MSB first. The bits are 32 ones, start `01`, opcode `01`, the 5-bit PHY address `PHY_ADDR`, the 5-bit register address, turnaround `10` and 16 data bits. `mdio_o` changes only on a falling edge of `mdc`, and `mdio_oe` is high for exactly the 64 bits of a frame.
- R3: The frames arrive in this order: 0x1F←0x8000 (hard reset), then link-up disable (0x0523←0x0001), then the master role (0x0834←0xC001), then 0x1F←0x4000 (soft reset), then link-up enable (0x0523←0x0000), then 0x1F←0x4000 (final soft reset). The total is 15 frames.
- R4: An extended register X is written with the value V in four frames: 0x0D←0x001F, 0x0E←X, 0x0D←0x401F, 0x0E←V.
- R5: Every frame the block issues is a write (opcode `01`). No read frame ever appears.
- R6: At least `HARD_WAIT_CYC` clock cycles pass between the end of the hard-reset frame and the start of the next frame. At least `SOFT_WAIT_CYC` cycles pass after the first soft-reset frame. Between other frames there is no settle wait.
- R7: `busy` is high from the cycle after `start` until the final frame ends. `cfg_done` then rises and stays high until the next `start`.
- R8: If `link_in` is high while the block waits for the link, `link_up` rises within 4 cycles.
- R9: If `link_in` stays low, `timeout` rises `LINK_TMO_CYC` cycles (±1) after `cfg_done` rises. `link_up` and `timeout` are never high together.
- R10: A `start` pulse during a sequence aborts it and clears `cfg_done`, `link_up` and `timeout`. The sequence then restarts with the hard-reset frame.
- R11: `link_in` has no effect while the configuration is still running: `link_up` stays 0 while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts or restarts the sequence |
| link_in | input | 1 | Asynchronous link indication from the PHY |
| mdc | output | 1 | Management clock, divided from `clk` |
| mdio_o | output | 1 | Management data driven to the pad |
| mdio_oe | output | 1 | Output enable of the data pad |
| busy | output | 1 | Configuration writes or settle waits in progress |
| cfg_done | output | 1 | All configuration frames have been sent |
| link_up | output | 1 | Link came up within the timer window |
| timeout | output | 1 | Link timer expired without a link |

## Verification
The bench builds the block with `MDC_HALF`=2, PHY address 0x03 and settle waits of 60 and 40 cycles. With these values a whole 15-frame sequence takes a few thousand cycles, so three complete runs fit comfortably. Because the two waits differ from each other and from the normal inter-frame gap of about 8 cycles, a wait placed after the wrong frame shows up as a gap mismatch. `LINK_TMO_CYC`=500 lets the bench measure the expiry cycle exactly, and the non-zero PHY address exercises that field of every frame.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;

    localparam int FRAME_BITS = 64;
    localparam int NUM_STEPS  = 17;
    localparam int STEP_W     = 5;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [1:0] {
        K_WRITE     = 2'd0,
        K_WAIT_HARD = 2'd1,
        K_WAIT_SOFT = 2'd2
    } step_kind_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [4:0]  regad;
        logic [15:0] data;
    } step_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_XFER, S_WAIT, S_LINK, S_UP, S_TMO
    } seq_state_e;

    // Direct register and command values
    localparam logic [4:0]  REG_BASIC_CTL = 5'h1F;
    localparam logic [4:0]  REG_MMD_CTL   = 5'h0D;
    localparam logic [4:0]  REG_MMD_DAT   = 5'h0E;
    localparam logic [15:0] CMD_HARD_RST  = 16'h8000;
    localparam logic [15:0] CMD_SOFT_RST  = 16'h4000;
    localparam logic [15:0] MMD_DEVICE    = 16'h001F;
    localparam logic [15:0] MMD_DATA_NOINC = 16'h4000;

    // Extended targets
    localparam logic [15:0] EXT_LINK_GATE = 16'h0523;
    localparam logic [15:0] EXT_ROLE      = 16'h0834;
    localparam logic [15:0] GATE_HOLD     = 16'h0001;
    localparam logic [15:0] GATE_RELEASE  = 16'h0000;
    localparam logic [15:0] ROLE_MASTER   = 16'hC001;

    function automatic step_t wr(input logic [4:0] r, input logic [15:0] d);
        step_t s;
        s.kind  = K_WRITE;
        s.regad = r;
        s.data  = d;
        return s;
    endfunction

    function automatic step_t pause(input step_kind_e k);
        step_t s;
        s.kind  = k;
        s.regad = 5'h00;
        s.data  = 16'h0000;
        return s;
    endfunction

    // One of the four frames of an indirect extended-register write
    function automatic step_t ext_part(input logic [1:0] phase,
                                       input logic [15:0] addr,
                                       input logic [15:0] val);
        case (phase)
            2'd0:    return wr(REG_MMD_CTL, MMD_DEVICE);
            2'd1:    return wr(REG_MMD_DAT, addr);
            2'd2:    return wr(REG_MMD_CTL, MMD_DATA_NOINC | MMD_DEVICE);
            default: return wr(REG_MMD_DAT, val);
        endcase
    endfunction

    function automatic step_t step_at(input logic [STEP_W-1:0] idx);
        if (idx == 5'd0)       return wr(REG_BASIC_CTL, CMD_HARD_RST);
        else if (idx == 5'd1)  return pause(K_WAIT_HARD);
        else if (idx <= 5'd5)  return ext_part(2'(idx - 5'd2), EXT_LINK_GATE, GATE_HOLD);
        else if (idx <= 5'd9)  return ext_part(2'(idx - 5'd6), EXT_ROLE, ROLE_MASTER);
        else if (idx == 5'd10) return wr(REG_BASIC_CTL, CMD_SOFT_RST);
        else if (idx == 5'd11) return pause(K_WAIT_SOFT);
        else if (idx <= 5'd15) return ext_part(2'(idx - 5'd12), EXT_LINK_GATE, GATE_RELEASE);
        else                   return wr(REG_BASIC_CTL, CMD_SOFT_RST);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [4:0] phy,
                                                          input logic [4:0] r,
                                                          input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, r, 2'b10, d};
    endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
    parameter int MDC_HALF = 40
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic fall_tick
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] LIM = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt;
    logic          at_lim;

    assign at_lim    = (cnt == LIM);
    assign fall_tick = at_lim && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_lim) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the clock toggles only after a full half period
    p_half_period_r2: assert property (@(posedge clk) disable iff (rst)
        (mdc != $past(mdc)) |-> ($past(cnt) == LIM));

endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx
    import mdio_seq_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        go,
    input  logic [4:0]  regad,
    input  logic [15:0] data,
    input  logic        fall_tick,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done
);
    localparam int BCW = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [BCW-1:0]        bitcnt;
    logic                  active;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            shreg   <= '0;
            bitcnt  <= '0;
            active  <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                shreg  <= build_frame(PHY_ADDR, regad, data);
                bitcnt <= BCW'(FRAME_BITS);
                active <= 1'b1;
            end else if (active && fall_tick) begin
                if (bitcnt != '0) begin
                    mdio_o  <= shreg[FRAME_BITS-1];
                    mdio_oe <= 1'b1;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                    bitcnt  <= bitcnt - 1'b1;
                end else begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                    active  <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R2: data moves only on a falling clock edge
    p_change_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(fall_tick));

    // R2: the output enable only opens on a falling edge
    p_oe_opens_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && !$past(mdio_oe)) |-> $past(fall_tick));

    p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= BCW'(FRAME_BITS));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import mdio_seq_pkg::*;
#(
    parameter int HARD_WAIT_CYC = 40000,
    parameter int SOFT_WAIT_CYC = 40000,
    parameter int LINK_TMO_CYC  = 10000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        link_in,
    input  logic        tx_done,
    output logic        go,
    output logic [4:0]  wr_reg,
    output logic [15:0] wr_data,
    output logic        busy,
    output logic        cfg_done,
    output logic        link_up,
    output logic        timeout
);
    localparam int WAIT_MAX = (HARD_WAIT_CYC > SOFT_WAIT_CYC) ? HARD_WAIT_CYC : SOFT_WAIT_CYC;
    localparam int WCW = $clog2(WAIT_MAX + 1);
    localparam int LCW = $clog2(LINK_TMO_CYC + 1);
    localparam logic [WCW-1:0] HARD_LOAD = WCW'(HARD_WAIT_CYC - 1);
    localparam logic [WCW-1:0] SOFT_LOAD = WCW'(SOFT_WAIT_CYC - 1);
    localparam logic [LCW-1:0] LINK_LIM  = LCW'(LINK_TMO_CYC - 1);

    seq_state_e        state;
    logic [STEP_W-1:0] sidx;
    logic [WCW-1:0]    wcnt;
    logic [LCW-1:0]    lcnt;
    logic [1:0]        link_sync;
    step_t             cur;

    always_comb begin
        cur     = step_at(sidx);
        go      = (state == S_ISSUE) && (cur.kind == K_WRITE);
        wr_reg  = cur.regad;
        wr_data = cur.data;
        busy    = (state == S_ISSUE) || (state == S_XFER) || (state == S_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_sync <= 2'b00;
        end else begin
            link_sync <= {link_sync[0], link_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            sidx     <= '0;
            wcnt     <= '0;
            lcnt     <= '0;
            cfg_done <= 1'b0;
            link_up  <= 1'b0;
            timeout  <= 1'b0;
        end else if (start) begin
            state    <= S_ISSUE;
            sidx     <= '0;
            wcnt     <= '0;
            lcnt     <= '0;
            cfg_done <= 1'b0;
            link_up  <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            case (state)
                S_ISSUE: begin
                    if (cur.kind == K_WRITE) begin
                        state <= S_XFER;
                    end else begin
                        wcnt  <= (cur.kind == K_WAIT_HARD) ? HARD_LOAD : SOFT_LOAD;
                        state <= S_WAIT;
                    end
                end
                S_XFER: begin
                    if (tx_done) begin
                        if (sidx == LAST_STEP) begin
                            cfg_done <= 1'b1;
                            lcnt     <= '0;
                            state    <= S_LINK;
                        end else begin
                            sidx  <= sidx + 1'b1;
                            state <= S_ISSUE;
                        end
                    end
                end
                S_WAIT: begin
                    if (wcnt == '0) begin
                        sidx  <= sidx + 1'b1;
                        state <= S_ISSUE;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                S_LINK: begin
                    if (link_sync[1]) begin
                        link_up <= 1'b1;
                        state   <= S_UP;
                    end else if (lcnt == LINK_LIM) begin
                        timeout <= 1'b1;
                        state   <= S_TMO;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    p_status_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(link_up && timeout));

    p_link_window_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_LINK) |-> (lcnt <= LINK_LIM));

    p_quiet_link_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !link_up);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && !start) |=> cfg_done);

    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !cfg_done && !link_up && !timeout && (sidx == '0)));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_done) |-> ($past(sidx) == LAST_STEP) && $past(tx_done));

endmodule

// File: rtl/mdio_bringup_seq.sv
module mdio_bringup_seq
    import mdio_seq_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR      = 5'd0,
    parameter int         MDC_HALF      = 40,
    parameter int         HARD_WAIT_CYC = 40000,
    parameter int         SOFT_WAIT_CYC = 40000,
    parameter int         LINK_TMO_CYC  = 10000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic link_in,
    output logic mdc,
    output logic mdio_o,
    output logic mdio_oe,
    output logic busy,
    output logic cfg_done,
    output logic link_up,
    output logic timeout
);
    logic        fall_tick;
    logic        go;
    logic        tx_done;
    logic [4:0]  wr_reg;
    logic [15:0] wr_data;

    mdc_gen #(.MDC_HALF(MDC_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .fall_tick (fall_tick)
    );

    seq_ctrl #(
        .HARD_WAIT_CYC (HARD_WAIT_CYC),
        .SOFT_WAIT_CYC (SOFT_WAIT_CYC),
        .LINK_TMO_CYC  (LINK_TMO_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .link_in  (link_in),
        .tx_done  (tx_done),
        .go       (go),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data),
        .busy     (busy),
        .cfg_done (cfg_done),
        .link_up  (link_up),
        .timeout  (timeout)
    );

    mdio_frame_tx #(.PHY_ADDR(PHY_ADDR)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .abort     (start),
        .go        (go),
        .regad     (wr_reg),
        .data      (wr_data),
        .fall_tick (fall_tick),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (tx_done)
    );

    // R1: pins quiet in reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!mdio_oe && !cfg_done && !link_up && !timeout));

endmodule

// File: tb/mdio_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module mdio_bringup_seq_tb_top;

    localparam logic [4:0] T_PHY  = 5'h03;
    localparam int         T_HALF = 2;
    localparam int         T_HARD = 60;
    localparam int         T_SOFT = 40;
    localparam int         T_TMO  = 500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic link_in = 1'b0;
    logic mdc, mdio_o, mdio_oe, busy, cfg_done, link_up, timeout;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int frames_run = 0;
    int quiet_bad = 0;
    bit finished = 1'b0;

    logic [20:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_bringup_seq #(
        .PHY_ADDR(T_PHY), .MDC_HALF(T_HALF), .HARD_WAIT_CYC(T_HARD),
        .SOFT_WAIT_CYC(T_SOFT), .LINK_TMO_CYC(T_TMO)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .link_in(link_in),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
        .cfg_done(cfg_done), .link_up(link_up), .timeout(timeout)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_wr(input logic [4:0] r, input logic [15:0] d);
        exp_q.push_back({r, d});
    endtask

    task automatic push_ext(input logic [15:0] a, input logic [15:0] v);
        push_wr(5'h0D, 16'h001F);
        push_wr(5'h0E, a);
        push_wr(5'h0D, 16'h401F);
        push_wr(5'h0E, v);
    endtask

    task automatic push_seq();
        exp_q.delete();
        push_wr(5'h1F, 16'h8000);
        push_ext(16'h0523, 16'h0001);
        push_ext(16'h0834, 16'hC001);
        push_wr(5'h1F, 16'h4000);
        push_ext(16'h0523, 16'h0000);
        push_wr(5'h1F, 16'h4000);
    endtask

    task automatic pulse_start();
        @(posedge clk); #1;
        start = 1'b1;
        frames_run = 0;
        push_seq();
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // Monitor: rebuild frames from the pins, compare against the queue
    logic [63:0] shf;
    int nb = 0;
    int last_end = 0;
    logic prev_mdc = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            nb = 0;
            prev_mdc = 1'b0;
        end else begin
            if (busy && link_up) quiet_bad++;
            if (!mdio_oe) begin
                nb = 0;
            end else if (mdc && !prev_mdc) begin
                if (nb == 0 && frames_run > 0) begin
                    if (frames_run == 1)
                        chk((cyc - last_end) >= T_HARD, "R6 hard-reset settle gap", cyc - last_end, T_HARD);
                    if (frames_run == 10)
                        chk((cyc - last_end) >= T_SOFT, "R6 soft-reset settle gap", cyc - last_end, T_SOFT);
                    if (frames_run == 2)
                        chk((cyc - last_end) < T_SOFT, "R6 no wait between plain writes", cyc - last_end, T_SOFT);
                end
                shf = {shf[62:0], mdio_o};
                nb++;
                if (nb == 64) begin
                    chk(shf[63:32] == 32'hFFFF_FFFF, "R2 preamble", shf[63:32], 32'hFFFF_FFFF);
                    chk(shf[31:30] == 2'b01, "R2 start bits", 32'(shf[31:30]), 32'h1);
                    chk(shf[29:28] == 2'b01, "R5 write opcode", 32'(shf[29:28]), 32'h1);
                    chk(shf[27:23] == T_PHY, "R2 phy address", 32'(shf[27:23]), 32'(T_PHY));
                    chk(shf[17:16] == 2'b10, "R2 turnaround", 32'(shf[17:16]), 32'h2);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected extra frame", 32'({shf[22:18], shf[15:0]}), 32'h0);
                    end else begin
                        logic [20:0] e;
                        e = exp_q.pop_front();
                        if (e[20:16] == 5'h0D || e[20:16] == 5'h0E)
                            chk({shf[22:18], shf[15:0]} == e, "R4 indirect frame reg/data",
                                32'({shf[22:18], shf[15:0]}), 32'(e));
                        else
                            chk({shf[22:18], shf[15:0]} == e, "R3 direct frame reg/data",
                                32'({shf[22:18], shf[15:0]}), 32'(e));
                    end
                    last_end = cyc;
                    frames_run++;
                    nb = 0;
                end
            end
            prev_mdc = mdc;
        end
    end

    // Watchdog
    initial begin
        while (cyc < 150000 && !finished) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!mdio_oe && !busy && !cfg_done && !link_up && !timeout, "R1 outputs in reset",
            {27'd0, mdio_oe, busy, cfg_done, link_up, timeout}, 32'h0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(!mdio_oe && !busy && !cfg_done && !link_up && !timeout, "R1 outputs after reset",
            {27'd0, mdio_oe, busy, cfg_done, link_up, timeout}, 32'h0);

        // Run A: no link, expect timeout
        link_in = 1'b0;
        pulse_start();
        @(negedge clk);
        chk(busy == 1'b1, "R7 busy after start", 32'(busy), 32'h1);
        while (!cfg_done) @(negedge clk);
        t0 = cyc;
        chk(frames_run == 15, "R7 done after final frame", frames_run, 15);
        chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
        chk(!busy, "R7 busy low at done", 32'(busy), 32'h0);
        while (!timeout) @(negedge clk);
        chk((cyc - t0) >= T_TMO && (cyc - t0) <= T_TMO + 1, "R9 timeout delay", cyc - t0, T_TMO);
        chk(!link_up, "R9 no link_up with timeout", 32'(link_up), 32'h0);
        chk(cfg_done, "R7 done held", 32'(cfg_done), 32'h1);

        // Run B: link already high during configuration
        link_in = 1'b1;
        pulse_start();
        @(negedge clk);
        chk(!timeout && !cfg_done, "R10 status cleared on start",
            {30'd0, timeout, cfg_done}, 32'h0);
        while (!cfg_done) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all frames seen run B", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        chk(link_up && !timeout, "R8 link_up after config", {30'd0, link_up, timeout}, 32'h2);
        chk(quiet_bad == 0, "R11 link ignored while busy", quiet_bad, 0);

        // Run C: abort after three frames, restart
        link_in = 1'b0;
        pulse_start();
        @(negedge clk);
        chk(!link_up && busy, "R10 link_up cleared on restart", {30'd0, link_up, busy}, 32'h1);
        while (frames_run < 3) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_start();
        while (!cfg_done) @(negedge clk);
        chk(frames_run == 15, "R10 full sequence after abort", frames_run, 15);
        chk(exp_q.size() == 0, "R10 queue drained after abort", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        chk(!link_up && !timeout, "R9 no early status", {30'd0, link_up, timeout}, 32'h0);
        @(posedge clk); #1 link_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(link_up && !timeout, "R8 link_up on late link", {30'd0, link_up, timeout}, 32'h2);
        chk(quiet_bad == 0, "R11 link_up never during busy", quiet_bad, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule